// File: doc/BRIEF.md
# Cycle-Steal Service Sequencer (Device Side)

This block sits in a device attachment and answers the channel's cycle-steal service handshake. Once the poll logic reports that the device has won the poll, the sequencer claims the next rising edge of the service gate. It then drives the held address, the byte-transfer and input-transfer indicators and, for input transfers, the data word. After a programmable delay it raises service-gate-return. It keeps every driven signal unchanged until both the service gate and the data strobe are low.

On output transfers the channel supplies a data word with one odd-parity bit per byte. The data, the parity result and the status bus are sampled a programmable number of cycles after the synchronized strobe is seen high. They are not sampled on the strobe's leading edge. The sampled word is held in a shadow register and reaches the device-side result port only when the sequence ends with no error. An error on a burst transfer that is not the last one makes the next service sequence a dummy cycle. That cycle is a full handshake that commits nothing and accumulates no status.

Service gate, data strobe and status are asynchronous and pass through two-flop synchronizers. The channel data bus is sampled only once the settle delay has elapsed, when it is stable.

Top module: `cs_svc_seq`

## Requirements
- R1: The device claims a sequence only on a rising edge of the synchronized service gate seen after `poll_cap` was pulsed. A gate edge with no prior poll is ignored. A gate that is already high when the poll arrives does not claim until it falls and rises again.
- R2: On a claim the device latches `addr_in`, `xfer_byte`, `xfer_input` and `wdata_in`, and drives `addr_bus`. `cyc_byte` is driven high for byte transfers. For input transfers `cyc_input` is driven high and `data_out` carries the latched word. For output transfers `data_out` and `cyc_input` are 0. When no sequence is active all four outputs are 0.
- R3: `svc_gate_ret` rises exactly RET_DLY cycles (RET_DLY ≥ 1) after the driven outputs first become valid.
- R4: `addr_bus`, `data_out`, `cyc_byte` and `cyc_input` stay stable from the claim until the sequence ends.
- R5: Channel data, parity and status are sampled SETTLE cycles after the synchronized strobe is seen high. Values present only at the strobe's leading edge do not affect the result.
- R6: A sequence ends only when both the synchronized gate and the strobe are low. `svc_gate_ret` stays high until then, even while the strobe lingers after the gate has fallen. In the cycle the sequence ends, `done` pulses, `svc_gate_ret` drops and the driven outputs return to 0.
- R7: On output transfers each byte i of `ch_data` with `ch_par[i]` must have odd parity, so the XOR of the 9 bits is 1. Byte transfers check only byte 0. A parity error sets `done_err` with `done` and sets the sticky `err_flag`.
- R8: A nonzero sampled status counts as an error on both directions. On a non-dummy sequence, `stat_acc` ORs in the sampled status. `rx_valid` pulses with `done` and `rx_data` is updated only on an error-free output transfer. A byte transfer yields `rx_data` = {zeros, byte 0}.
- R9: If an error occurs on a transfer that was claimed with `burst_mode`=1 and `burst_last`=0, the next claimed sequence is a dummy cycle. During it `done_dummy` pulses with `done`, the previously held address and indicators are driven again, no new parameters are latched, `rx_valid` and `done_err` stay 0, `stat_acc` is unchanged and no further dummy is scheduled.
- R10: An error on a non-burst transfer, or on the last transfer of a burst, schedules no dummy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| poll_cap | input | 1 | One-cycle pulse: the poll was won |
| svc_gate | input | 1 | Service gate from the channel (asynchronous) |
| data_strobe | input | 1 | Data strobe from the channel (asynchronous) |
| status_in | input | SW | Status bus from the channel (asynchronous) |
| ch_data | input | DW | Data bus from the channel (output transfers) |
| ch_par | input | DW/8 | Odd parity bit per byte of `ch_data` |
| addr_in | input | AW | Device address for the next transfer |
| wdata_in | input | DW | Device data for the next input transfer |
| xfer_byte | input | 1 | Next transfer is a byte transfer |
| xfer_input | input | 1 | Next transfer is an input transfer (device to channel) |
| burst_mode | input | 1 | Next transfer belongs to a burst |
| burst_last | input | 1 | Next transfer is the last one of the burst |
| addr_bus | output | AW | Address driven to the channel |
| data_out | output | DW | Data driven to the channel on input transfers |
| cyc_byte | output | 1 | Byte-transfer indicator |
| cyc_input | output | 1 | Input-transfer indicator |
| svc_gate_ret | output | 1 | Service gate return |
| rx_data | output | DW | Committed data of the last good output transfer |
| rx_valid | output | 1 | Pulse: `rx_data` updated |
| done | output | 1 | Pulse: a service sequence ended |
| done_err | output | 1 | With `done`: the sequence had an error |
| done_dummy | output | 1 | With `done`: the sequence was a dummy cycle |
| err_flag | output | 1 | Sticky error indication |
| stat_acc | output | SW | OR of the status of all non-dummy sequences |

## Verification
The hardest situation to reach is a dummy cycle whose own parameters differ from the held ones. The bench runs a burst transfer that is not the last, with an error status. It then changes `addr_in` and the direction inputs and presents a fresh nonzero status during the following handshake. The outputs must show the old address, no commit, no error and an unchanged accumulated status. A second hard case is data and status that are wrong at the strobe's leading edge and become correct a few cycles later. The bench presents such values, then drops the gate well before the strobe, so that both the late sampling and the wait for both signals are exercised.

// File: rtl/cs_svc_pkg.sv
// Shared types of the cycle-steal service sequencer.
package cs_svc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_DRIVE,
        ST_RETURN,
        ST_STROBE_WAIT,
        ST_COMPLETE,
        ST_DUMMY
    } cs_state_t;
endpackage

// File: rtl/cs_sync.sv
// Two-flop synchronizer for W independent asynchronous inputs.
// Assumes each bit is a level that is held for several clocks.
module cs_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] meta;

    // Purpose: two-stage resampling into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta   <= '0;
            q_sync <= '0;
        end else begin
            meta   <= d_async;
            q_sync <= meta;
        end
    end
endmodule

// File: rtl/cs_parity_chk.sv
// Per-byte odd parity checker. err[i] is 1 when byte i together with
// its parity bit holds an even number of ones. Assumes DW is a multiple of 8.
module cs_parity_chk #(
    parameter int DW = 16,
    localparam int NB = DW / 8
) (
    input  logic [DW-1:0] data,
    input  logic [NB-1:0] par,
    output logic [NB-1:0] err
);
    for (genvar i = 0; i < NB; i++) begin : g_byte
        // Purpose: odd-parity test of one byte.
        assign err[i] = ~(^{data[8*i +: 8], par[i]});
    end
endmodule

// File: rtl/cs_svc_seq.sv
// Device-side cycle-steal service sequencer.
// Claims the first synchronized service-gate rise after a poll pulse,
// drives the held transfer parameters, answers with gate return, samples
// channel data/status a settle delay after the strobe and ends only when
// gate and strobe are both low. Error on a non-last burst transfer makes
// the next sequence a dummy. Assumes RET_DLY >= 1, SETTLE >= 1, DW >= 16.
module cs_svc_seq #(
    parameter int AW      = 16,
    parameter int DW      = 16,
    parameter int SW      = 4,
    parameter int RET_DLY = 2,
    parameter int SETTLE  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            poll_cap,
    input  logic            svc_gate,
    input  logic            data_strobe,
    input  logic [SW-1:0]   status_in,
    input  logic [DW-1:0]   ch_data,
    input  logic [DW/8-1:0] ch_par,
    input  logic [AW-1:0]   addr_in,
    input  logic [DW-1:0]   wdata_in,
    input  logic            xfer_byte,
    input  logic            xfer_input,
    input  logic            burst_mode,
    input  logic            burst_last,
    output logic [AW-1:0]   addr_bus,
    output logic [DW-1:0]   data_out,
    output logic            cyc_byte,
    output logic            cyc_input,
    output logic            svc_gate_ret,
    output logic [DW-1:0]   rx_data,
    output logic            rx_valid,
    output logic            done,
    output logic            done_err,
    output logic            done_dummy,
    output logic            err_flag,
    output logic [SW-1:0]   stat_acc
);
    import cs_svc_pkg::*;

    localparam int NB   = DW / 8;
    localparam int MAXD = (RET_DLY > SETTLE) ? RET_DLY : SETTLE;
    localparam int CW   = $clog2(MAXD + 1);

    cs_state_t      state;
    logic [CW-1:0]  cnt;
    logic           gate_s, strobe_s, gate_d;
    logic [SW-1:0]  stat_s;
    logic           gate_rise;
    logic [NB-1:0]  perr;

    // Held transfer parameters and shadow capture registers
    logic [AW-1:0]  h_addr;
    logic [DW-1:0]  h_wdata;
    logic           h_byte, h_input, h_burst, h_last;
    logic           drive_on, is_dummy, dummy_pend;
    logic [DW-1:0]  cap_data;
    logic [NB-1:0]  cap_perr;
    logic [SW-1:0]  cap_stat;
    logic           perr_sel, err_now;

    cs_sync #(.W(SW + 2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({status_in, data_strobe, svc_gate}),
        .q_sync  ({stat_s, strobe_s, gate_s})
    );

    cs_parity_chk #(.DW(DW)) u_par (
        .data (ch_data),
        .par  (ch_par),
        .err  (perr)
    );

    // Purpose: delayed gate copy for leading-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) gate_d <= 1'b0;
        else        gate_d <= gate_s;
    end

    assign gate_rise = gate_s & ~gate_d;

    // Purpose: error verdict of the captured transfer.
    always_comb begin
        perr_sel = h_byte ? cap_perr[0] : |cap_perr;
        err_now  = ~is_dummy & ((|cap_stat) | (~h_input & perr_sel));
    end

    // Purpose: device-side outputs driven from held parameters.
    always_comb begin
        addr_bus  = drive_on ? h_addr : '0;
        cyc_byte  = drive_on & h_byte;
        cyc_input = drive_on & h_input;
        data_out  = (drive_on & h_input) ? h_wdata : '0;
    end

    // Purpose: service-sequence state machine with capture and commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            cnt          <= '0;
            h_addr       <= '0;
            h_wdata      <= '0;
            h_byte       <= 1'b0;
            h_input      <= 1'b0;
            h_burst      <= 1'b0;
            h_last       <= 1'b0;
            drive_on     <= 1'b0;
            is_dummy     <= 1'b0;
            dummy_pend   <= 1'b0;
            cap_data     <= '0;
            cap_perr     <= '0;
            cap_stat     <= '0;
            svc_gate_ret <= 1'b0;
            rx_data      <= '0;
            rx_valid     <= 1'b0;
            done         <= 1'b0;
            done_err     <= 1'b0;
            done_dummy   <= 1'b0;
            err_flag     <= 1'b0;
            stat_acc     <= '0;
        end else begin
            rx_valid   <= 1'b0;
            done       <= 1'b0;
            done_err   <= 1'b0;
            done_dummy <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (poll_cap) state <= dummy_pend ? ST_DUMMY : ST_ARMED;
                end
                ST_ARMED, ST_DUMMY: begin
                    if (gate_rise) begin
                        state    <= ST_DRIVE;
                        cnt      <= CW'(RET_DLY - 1);
                        drive_on <= 1'b1;
                        is_dummy <= (state == ST_DUMMY);
                        if (state == ST_ARMED) begin
                            h_addr  <= addr_in;
                            h_wdata <= wdata_in;
                            h_byte  <= xfer_byte;
                            h_input <= xfer_input;
                            h_burst <= burst_mode;
                            h_last  <= burst_last;
                        end
                    end
                end
                ST_DRIVE: begin
                    if (cnt == '0) begin
                        state        <= ST_RETURN;
                        svc_gate_ret <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_RETURN: begin
                    if (strobe_s) begin
                        state <= ST_STROBE_WAIT;
                        cnt   <= CW'(SETTLE - 1);
                    end
                end
                ST_STROBE_WAIT: begin
                    if (cnt == '0) begin
                        state    <= ST_COMPLETE;
                        cap_data <= ch_data;
                        cap_perr <= perr;
                        cap_stat <= stat_s;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_COMPLETE: begin
                    if (!gate_s && !strobe_s) begin
                        state        <= ST_IDLE;
                        svc_gate_ret <= 1'b0;
                        drive_on     <= 1'b0;
                        done         <= 1'b1;
                        done_err     <= err_now;
                        done_dummy   <= is_dummy;
                        dummy_pend   <= err_now & h_burst & ~h_last;
                        if (!is_dummy) stat_acc <= stat_acc | cap_stat;
                        if (err_now)   err_flag <= 1'b1;
                        if (!err_now && !h_input && !is_dummy) begin
                            rx_valid <= 1'b1;
                            rx_data  <= h_byte ? {{(DW-8){1'b0}}, cap_data[7:0]}
                                               : cap_data;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cs_svc_seq_chk.sv
// Property checker for cs_svc_seq, attached by bind below.
// Assumes the synchronized gate/strobe and the state are brought out.
module cs_svc_seq_chk #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input cs_svc_pkg::cs_state_t state,
    input logic                  gate_s,
    input logic                  strobe_s,
    input logic                  svc_gate_ret,
    input logic [AW-1:0]         addr_bus,
    input logic [DW-1:0]         data_out,
    input logic                  cyc_byte,
    input logic                  cyc_input,
    input logic                  done,
    input logic                  done_err,
    input logic                  done_dummy,
    input logic                  rx_valid
);
    import cs_svc_pkg::*;

    a_r1_no_return_unclaimed: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_ARMED || state == ST_DUMMY) |-> !svc_gate_ret);

    a_r3_return_after_drive: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(svc_gate_ret) |-> $past(state) == ST_DRIVE && $stable(addr_bus));

    a_r4_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_gate_ret && $past(svc_gate_ret)) |->
            ($stable(addr_bus) && $stable(data_out) && $stable(cyc_byte) && $stable(cyc_input)));

    a_r6_end_needs_both_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(svc_gate_ret) |-> (!$past(gate_s) && !$past(strobe_s) && done));

    a_r8_commit_only_clean: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (done && !done_err));

    a_r9_dummy_silent: assert property (@(posedge clk) disable iff (!rst_n)
        done_dummy |-> (!rx_valid && !done_err));
endmodule

bind cs_svc_seq cs_svc_seq_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .state        (state),
    .gate_s       (gate_s),
    .strobe_s     (strobe_s),
    .svc_gate_ret (svc_gate_ret),
    .addr_bus     (addr_bus),
    .data_out     (data_out),
    .cyc_byte     (cyc_byte),
    .cyc_input    (cyc_input),
    .done         (done),
    .done_err     (done_err),
    .done_dummy   (done_dummy),
    .rx_valid     (rx_valid)
);

// File: tb/cs_svc_seq_test.sv
// Scoreboard bench: the channel task pushes the expected outcome of each
// sequence, the monitor pops it when done pulses.
module cs_svc_seq_test;
    localparam int AW = 16, DW = 16, SW = 4, RET_DLY = 2, SETTLE = 4;
    localparam int NB = DW / 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic poll_cap = 0, svc_gate = 0, data_strobe = 0;
    logic [SW-1:0] status_in = '0;
    logic [DW-1:0] ch_data = '0, wdata_in = '0;
    logic [NB-1:0] ch_par = '0;
    logic [AW-1:0] addr_in = '0;
    logic xfer_byte = 0, xfer_input = 0, burst_mode = 0, burst_last = 0;
    logic [AW-1:0] addr_bus;
    logic [DW-1:0] data_out, rx_data;
    logic cyc_byte, cyc_input, svc_gate_ret, rx_valid, done, done_err, done_dummy, err_flag;
    logic [SW-1:0] stat_acc;

    cs_svc_seq #(.AW(AW), .DW(DW), .SW(SW), .RET_DLY(RET_DLY), .SETTLE(SETTLE)) uut (
        .clk(clk), .rst_n(rst_n), .poll_cap(poll_cap), .svc_gate(svc_gate),
        .data_strobe(data_strobe), .status_in(status_in), .ch_data(ch_data),
        .ch_par(ch_par), .addr_in(addr_in), .wdata_in(wdata_in),
        .xfer_byte(xfer_byte), .xfer_input(xfer_input), .burst_mode(burst_mode),
        .burst_last(burst_last), .addr_bus(addr_bus), .data_out(data_out),
        .cyc_byte(cyc_byte), .cyc_input(cyc_input), .svc_gate_ret(svc_gate_ret),
        .rx_data(rx_data), .rx_valid(rx_valid), .done(done), .done_err(done_err),
        .done_dummy(done_dummy), .err_flag(err_flag), .stat_acc(stat_acc));

    always #2 clk = ~clk;

    typedef struct packed {
        logic          dummy;
        logic          err;
        logic          valid;
        logic [DW-1:0] data;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0, errors = 0;
    bit finished = 0;

    // Model state kept by the bench
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_wdata = '0;
    logic m_byte = 0, m_input = 0, m_pend = 0, m_flag = 0;
    logic [SW-1:0] m_acc = '0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Monitor: pops one expected item at every done pulse
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                check("R8 unexpected done", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check("R9 done_dummy", {31'd0, done_dummy}, {31'd0, e.dummy});
                check("R7 done_err", {31'd0, done_err}, {31'd0, e.err});
                check("R8 rx_valid", {31'd0, rx_valid}, {31'd0, e.valid});
                if (e.valid) check("R8 rx_data", {16'd0, rx_data}, {16'd0, e.data});
                check("R6 return low at end", {31'd0, svc_gate_ret}, 32'd0);
                check("R6 outputs released", {16'd0, addr_bus}, 32'd0);
            end
        end
    end

    task automatic wait_ret(output int ok);
        ok = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (svc_gate_ret) begin ok = 1; break; end
        end
    endtask

    // Driver: one full channel handshake with expectation computed from R1..R10
    task automatic do_seq(input bit do_poll, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                          input bit byt, input bit inp, input bit burst, input bit last,
                          input logic [DW-1:0] cd, input logic [NB-1:0] cp,
                          input logic [SW-1:0] st, input bit late, input bit stagger);
        exp_t e;
        bit dummy, perr, err;
        int n, ok;
        logic [AW-1:0] ea;
        logic [DW-1:0] ed;
        logic eb, ei;
        dummy = m_pend;
        @(negedge clk);
        addr_in = a; wdata_in = wd; xfer_byte = byt; xfer_input = inp;
        burst_mode = burst; burst_last = last;
        if (do_poll) begin
            poll_cap = 1; @(negedge clk); poll_cap = 0;
        end
        if (!dummy) begin
            m_addr = a; m_wdata = wd; m_byte = byt; m_input = inp;
        end
        ea = m_addr; eb = m_byte; ei = m_input; ed = m_input ? m_wdata : '0;
        perr = 0;
        for (int i = 0; i < NB; i++)
            if ((i == 0 || !m_byte) && !(^{cd[8*i +: 8], cp[i]})) perr = 1;
        err = !dummy && ((st != 0) || (!m_input && perr));
        e.dummy = dummy; e.err = err;
        e.valid = !dummy && !err && !m_input;
        e.data  = m_byte ? {8'h00, cd[7:0]} : cd;
        exp_q.push_back(e);
        if (!dummy) m_acc = m_acc | st;
        if (err) m_flag = 1;
        m_pend = err && burst && !last;

        @(negedge clk); svc_gate = 1;
        n = 0;
        while (addr_bus !== ea && n < 100) begin @(negedge clk); n++; end
        check("R2 addr_bus", {16'd0, addr_bus}, {16'd0, ea});
        check("R2 cyc_byte", {31'd0, cyc_byte}, {31'd0, eb});
        check("R2 cyc_input", {31'd0, cyc_input}, {31'd0, ei});
        check("R2 data_out", {16'd0, data_out}, {16'd0, ed});
        n = 0;
        while (!svc_gate_ret && n < 100) begin @(negedge clk); n++; end
        check("R3 return delay", n, RET_DLY);
        @(negedge clk);
        if (late) begin
            ch_data = ~cd; ch_par = cp; status_in = st ^ 4'hF;
        end else begin
            ch_data = cd; ch_par = cp; status_in = st;
        end
        data_strobe = 1;
        repeat (2) @(negedge clk);
        ch_data = cd; ch_par = cp; status_in = st;
        repeat (12) @(negedge clk);
        check("R4 addr held", {16'd0, addr_bus}, {16'd0, ea});
        check("R4 data held", {16'd0, data_out}, {16'd0, ed});
        if (stagger) begin
            svc_gate = 0;
            repeat (6) @(negedge clk);
            check("R6 return held while strobe high", {31'd0, svc_gate_ret}, 32'd1);
            check("R6 addr held while strobe high", {16'd0, addr_bus}, {16'd0, ea});
            data_strobe = 0;
        end else begin
            svc_gate = 0; data_strobe = 0;
        end
        ok = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (done) begin ok = 1; break; end
        end
        check("R6 sequence ended", ok, 1);
        @(negedge clk);
        status_in = '0;
        check("R8 stat_acc", {28'd0, stat_acc}, {28'd0, m_acc});
        check("R7 err_flag", {31'd0, err_flag}, {31'd0, m_flag});
    endtask

    initial begin
        #400000;
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int ok;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R2 reset addr_bus", {16'd0, addr_bus}, 32'd0);
        check("R6 reset return", {31'd0, svc_gate_ret}, 32'd0);
        check("R8 reset rx_valid/err_flag", {30'd0, rx_valid, err_flag}, 32'd0);

        // R1: gate edge without a poll is ignored
        svc_gate = 1;
        wait_ret(ok);
        check("R1 no claim without poll", ok, 0);
        check("R1 no drive without poll", {16'd0, addr_bus}, 32'd0);
        svc_gate = 0;
        repeat (4) @(negedge clk);

        // R1: poll while gate already high does not claim on that level
        svc_gate = 1; repeat (4) @(negedge clk);
        addr_in = 16'h1234; poll_cap = 1; @(negedge clk); poll_cap = 0;
        wait_ret(ok);
        check("R1 no claim on held-high gate", ok, 0);
        svc_gate = 0; repeat (4) @(negedge clk);
        // armed: next rise claims (no new poll)
        do_seq(0, 16'h1234, 16'h0, 0, 0, 0, 0, 16'hA55A, 2'b11, 4'h0, 0, 0);

        // R2/R8: input byte transfer
        do_seq(1, 16'h0042, 16'h00C3, 1, 1, 0, 0, 16'h0000, 2'b11, 4'h0, 0, 0);
        // R7 R10: output word with bad parity on byte 1, non-burst
        do_seq(1, 16'h0100, 16'h0, 0, 0, 0, 0, 16'h0301, 2'b00, 4'h0, 0, 0);
        // R5 R6: late-valid data and status, strobe outlasts gate
        do_seq(1, 16'h0200, 16'h0, 0, 0, 0, 0, 16'h0F0F, 2'b11, 4'h0, 1, 1);
        // R9: burst non-last with error status, then dummy with new params
        do_seq(1, 16'h0300, 16'h0, 0, 0, 1, 0, 16'h1111, 2'b11, 4'h2, 0, 0);
        do_seq(1, 16'h7777, 16'hBEEF, 1, 1, 1, 0, 16'h2222, 2'b00, 4'h4, 0, 1);
        // R7: byte output, upper byte parity bad but ignored
        do_seq(1, 16'h0400, 16'h0, 1, 0, 0, 0, 16'hFF80, 2'b00, 4'h0, 0, 0);
        // R10: error on last burst transfer schedules no dummy
        do_seq(1, 16'h0500, 16'h0, 0, 0, 1, 1, 16'h5555, 2'b11, 4'h8, 0, 0);
        do_seq(1, 16'h0600, 16'h0, 0, 0, 0, 0, 16'h0101, 2'b00, 4'h0, 0, 0);

        repeat (4) @(negedge clk);
        check("R8 scoreboard drained", exp_q.size(), 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule